// File: doc/BRIEF.md
# Super I/O Configuration Port

This block provides the configuration space of a legacy Super I/O controller on a byte-wide I/O bus. The space is reached through two bus addresses: an index port, which holds the number of the register to access, and a data port, which reads or writes the register picked by that index. After reset the space is locked. While it is locked, the only thing that matters is the bytes written to the index port, which are compared against a four-byte unlock key. When the full key has arrived, the space opens. It stays open until software writes the lock code to the lock register.

While the space is open, the host can do four things. It can select a logical device through the device-number register. It can read a fixed 16-bit chip identifier and a revision number. Any index of 0x30 or above is passed to the selected logical device over a sideband. That sideband carries the device number, the register index, write data and single-cycle read and write strobes, and it returns read data in the same cycle. Bus reads are combinational: `io_rdata` is valid in the same cycle as `io_rd`. Writes take effect at the next rising clock edge.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is locked, the key detector is at its first step, the device-number register is 0x00 and the stored index is 0x00.
- R2: Index-port writes (address 0x2E) of 0x87, 0x01, 0x55, 0x55, in that order, unlock the space. Data-port and other-address accesses between these writes do not disturb the sequence. Register access works from the cycle after the fourth byte.
- R3: While locked, an index-port write that does not match the expected key byte sends the detector back to its first step. If that byte is 0x87, it counts as the first key byte.
- R4: While locked, index-port and data-port reads return 0xFF and data-port writes change nothing.
- R5: While unlocked, an index-port write stores the byte as the current index, and index-port reads return it.
- R6: Register 0x07 is an 8-bit read/write logical-device number.
- R7: Registers 0x20 and 0x21 return the high and low byte of the 16-bit chip identifier (default 0x8728). Writes to them are ignored.
- R8: Register 0x22 returns the 4-bit revision (default 0x1) in bits 3:0, with bits 7:4 zero. It is read-only.
- R9: A data-port write (address 0x2F) of 0x02 with index 0x02 locks the space and sends the key detector to its first step. Any other value written there has no effect, and register 0x02 reads 0x00.
- R10: With index 0x30 or above, data-port writes raise `dev_wr` and data-port reads raise `dev_rd`, each in the same cycle as the bus strobe. `dev_sel` carries the device number, `dev_addr` the index and `dev_wdata` the bus data, and `io_rdata` returns `dev_rdata`.
- R11: Indices below 0x30 other than 0x07, 0x20, 0x21 and 0x22 read 0x00. Writes to them are ignored and are not forwarded.
- R12: When `io_rd` and `io_wr` are both high in one cycle, `io_rdata` shows the state from before that write.
- R13: Accesses to any other bus address read 0x00 and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O bus address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| dev_sel | output | 8 | Selected logical device number |
| dev_addr | output | 8 | Forwarded register index |
| dev_wdata | output | 8 | Forwarded write data |
| dev_wr | output | 1 | Forwarded write strobe |
| dev_rd | output | 1 | Forwarded read strobe |
| dev_rdata | input | 8 | Read data from the selected device |

## Verification
A read and a write can fall in the same cycle. The cases that matter are the last key byte arriving while the index port is read, and the lock write arriving while register 0x02 is read. In both, the read must return the state from before the edge. The bench provokes this directly for both events. It also raises both strobes at random on every port and every index. A bench model produces the read value from its own state, which it updates only after the cycle has been judged.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int KEY_LEN = 4;
  localparam logic [7:0] KEY_SEQ [KEY_LEN] = '{8'h87, 8'h01, 8'h55, 8'h55};

  localparam logic [7:0] IDX_LOCK   = 8'h02;
  localparam logic [7:0] LOCK_CODE  = 8'h02;
  localparam logic [7:0] IDX_LDN    = 8'h07;
  localparam logic [7:0] IDX_ID_HI  = 8'h20;
  localparam logic [7:0] IDX_ID_LO  = 8'h21;
  localparam logic [7:0] IDX_REV    = 8'h22;
  localparam logic [7:0] IDX_DEV_LO = 8'h30;
  localparam logic [7:0] READ_IDLE  = 8'hFF;
endpackage

// File: rtl/sio_rst_sync.sv
module sio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sio_key_unlock.sv
module sio_key_unlock
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  input  logic       lock_req,
  output logic       unlocked
);
  localparam int SW = (KEY_LEN > 2) ? $clog2(KEY_LEN) : 1;
  localparam logic [SW-1:0] LAST = SW'(KEY_LEN - 1);

  logic [KEY_LEN-1:0] key_hit;
  logic [SW-1:0]      step_q, step_d;
  logic               unl_q, unl_d;

  for (genvar k = 0; k < KEY_LEN; k++) begin : g_hit
    assign key_hit[k] = (wdata == KEY_SEQ[k]);
  end

  always_comb begin
    step_d = step_q;
    unl_d  = unl_q;
    if (unl_q) begin
      if (lock_req) begin
        unl_d  = 1'b0;
        step_d = '0;
      end
    end else if (idx_wr) begin
      if (key_hit[step_q]) begin
        if (step_q == LAST) begin
          unl_d  = 1'b1;
          step_d = '0;
        end else begin
          step_d = step_q + SW'(1);
        end
      end else begin
        step_d = key_hit[0] ? SW'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      unl_q  <= 1'b0;
    end else begin
      step_q <= step_d;
      unl_q  <= unl_d;
    end
  end

  assign unlocked = unl_q;

  a_r2_open_after_last_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unl_q) |-> $past(idx_wr && wdata == KEY_SEQ[KEY_LEN-1]));
  a_r9_close_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unl_q) |-> $past(lock_req));
  a_r3_step_idle_when_open: assert property (@(posedge clk) disable iff (!rst_n)
    unl_q |-> step_q == '0);
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'h8728,
  parameter logic [3:0]  CHIP_REV = 4'h1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       unlocked,
  input  logic       idx_wr,
  input  logic       dat_wr,
  input  logic       dat_rd,
  input  logic [7:0] wdata,
  input  logic [7:0] dev_rdata,
  output logic [7:0] idx,
  output logic [7:0] cfg_rdata,
  output logic       lock_req,
  output logic [7:0] ldn,
  output logic       dev_wr,
  output logic       dev_rd
);
  logic [7:0] idx_q, idx_d;
  logic [7:0] ldn_q, ldn_d;
  logic       idx_en, ldn_en, dev_space;

  assign dev_space = (idx_q >= IDX_DEV_LO);
  assign idx_en    = idx_wr && unlocked;
  assign ldn_en    = dat_wr && unlocked && (idx_q == IDX_LDN);
  assign lock_req  = dat_wr && unlocked && (idx_q == IDX_LOCK) && (wdata == LOCK_CODE);
  assign dev_wr    = dat_wr && unlocked && dev_space;
  assign dev_rd    = dat_rd && unlocked && dev_space;

  always_comb begin
    idx_d = idx_en ? wdata : idx_q;
    ldn_d = ldn_en ? wdata : ldn_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ldn_q <= '0;
    end else begin
      idx_q <= idx_d;
      ldn_q <= ldn_d;
    end
  end

  always_comb begin
    unique case (idx_q)
      IDX_LDN:   cfg_rdata = ldn_q;
      IDX_ID_HI: cfg_rdata = CHIP_ID[15:8];
      IDX_ID_LO: cfg_rdata = CHIP_ID[7:0];
      IDX_REV:   cfg_rdata = {4'h0, CHIP_REV};
      default:   cfg_rdata = dev_space ? dev_rdata : 8'h00;
    endcase
  end

  assign idx = idx_q;
  assign ldn = ldn_q;

  a_r6_ldn_changes_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ldn_q) |-> $past(dat_wr && unlocked && idx_q == IDX_LDN));
  a_r5_idx_frozen_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked && $past(!unlocked) |-> $stable(idx_q));
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] IDX_PORT = 16'h002E,
  parameter logic [15:0] DAT_PORT = 16'h002F,
  parameter logic [15:0] CHIP_ID  = 16'h8728,
  parameter logic [3:0]  CHIP_REV = 4'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic [7:0]        dev_sel,
  output logic [7:0]        dev_addr,
  output logic [7:0]        dev_wdata,
  output logic              dev_wr,
  output logic              dev_rd,
  input  logic [7:0]        dev_rdata
);
  logic       rst_sync_n;
  logic       idx_hit, dat_hit;
  logic       unlocked, lock_req;
  logic [7:0] idx, cfg_rdata;

  assign idx_hit = (io_addr == ADDR_W'(IDX_PORT));
  assign dat_hit = (io_addr == ADDR_W'(DAT_PORT));

  sio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sio_key_unlock u_key (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .idx_wr   (io_wr && idx_hit),
    .wdata    (io_wdata),
    .lock_req (lock_req),
    .unlocked (unlocked)
  );

  sio_cfg_regs #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .unlocked  (unlocked),
    .idx_wr    (io_wr && idx_hit),
    .dat_wr    (io_wr && dat_hit),
    .dat_rd    (io_rd && dat_hit),
    .wdata     (io_wdata),
    .dev_rdata (dev_rdata),
    .idx       (idx),
    .cfg_rdata (cfg_rdata),
    .lock_req  (lock_req),
    .ldn       (dev_sel),
    .dev_wr    (dev_wr),
    .dev_rd    (dev_rd)
  );

  assign dev_addr  = idx;
  assign dev_wdata = io_wdata;

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd) begin
      if (idx_hit)      io_rdata = unlocked ? idx : READ_IDLE;
      else if (dat_hit) io_rdata = unlocked ? cfg_rdata : READ_IDLE;
    end
  end

  a_r4_locked_read_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_rd && dat_hit && !unlocked) |-> io_rdata == READ_IDLE);
  a_r10_strobes_need_open: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dev_wr || dev_rd) |-> unlocked && dat_hit);
  a_r13_foreign_addr_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!idx_hit && !dat_hit) |-> io_rdata == 8'h00 && !dev_wr && !dev_rd);
endmodule

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;
  localparam logic [15:0] IDX = 16'h002E;
  localparam logic [15:0] DAT = 16'h002F;
  localparam logic [15:0] OTH = 16'h0080;

  function automatic logic [7:0] dev_model(input logic [7:0] s, input logic [7:0] a);
    return s ^ {a[3:0], a[7:4]} ^ 8'h3C;
  endfunction

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [15:0] io_addr;
  logic        io_wr, io_rd;
  logic [7:0]  io_wdata, io_rdata;
  logic [7:0]  dev_sel, dev_addr, dev_wdata, dev_rdata;
  logic        dev_wr, dev_rd;

  assign dev_rdata = dev_model(dev_sel, dev_addr);

  sio_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_sel(dev_sel), .dev_addr(dev_addr),
    .dev_wdata(dev_wdata), .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_rdata(dev_rdata)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic       mlocked;
  int         mstep;
  logic [7:0] midx, mldn;
  logic [7:0] kb [4] = '{8'h87, 8'h01, 8'h55, 8'h55};

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    if (a == IDX) return mlocked ? 8'hFF : midx;
    if (a != DAT) return 8'h00;
    if (mlocked) return 8'hFF;
    case (midx)
      8'h07: return mldn;
      8'h20: return 8'h87;
      8'h21: return 8'h28;
      8'h22: return 8'h01;
      default: return (midx >= 8'h30) ? dev_model(mldn, midx) : 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [15:0] a, input bit w, input bit r);
    string s;
    if (a == IDX) s = mlocked ? "R4" : "R5";
    else if (a == DAT) begin
      if (mlocked) s = "R4";
      else case (midx)
        8'h07: s = "R6";
        8'h20, 8'h21: s = "R7";
        8'h22: s = "R8";
        8'h02: s = "R9";
        default: s = (midx >= 8'h30) ? "R10" : "R11";
      endcase
    end else s = "R13";
    if (w && r) s = {"R12 ", s};
    return s;
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    if (a == IDX) begin
      if (mlocked) begin
        if (d == kb[mstep]) begin
          if (mstep == 3) begin mlocked = 1'b0; mstep = 0; end
          else mstep++;
        end else mstep = (d == 8'h87) ? 1 : 0;
      end else midx = d;
    end else if (a == DAT && !mlocked) begin
      if (midx == 8'h07) mldn = d;
      else if (midx == 8'h02 && d == 8'h02) begin mlocked = 1'b1; mstep = 0; end
    end
  endtask

  task automatic op(input logic [15:0] a, input bit w, input bit r, input logic [7:0] d,
                    input string tag_in = "");
    string t;
    bit ew, er;
    @(negedge clk);
    io_addr = a; io_wr = w; io_rd = r; io_wdata = d;
    #2;
    t  = (tag_in != "") ? tag_in : tag_of(a, w, r);
    ew = w && a == DAT && !mlocked && midx >= 8'h30;
    er = r && a == DAT && !mlocked && midx >= 8'h30;
    if (r) chk(t, "io_rdata", io_rdata, exp_rd(a));
    chk(t, "dev_wr", {7'b0, dev_wr}, {7'b0, ew});
    chk(t, "dev_rd", {7'b0, dev_rd}, {7'b0, er});
    if (ew || er) begin
      chk("R10", "dev_sel", dev_sel, mldn);
      chk("R10", "dev_addr", dev_addr, midx);
    end
    if (ew) chk("R10", "dev_wdata", dev_wdata, d);
    @(posedge clk);
    #1;
    io_wr = 1'b0; io_rd = 1'b0;
    if (w) model_write(a, d);
  endtask

  task automatic send_key();
    for (int i = 0; i < 4; i++) op(IDX, 1'b1, 1'b0, kb[i]);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    logic [7:0]  d;
    bit w, r;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; io_addr = '0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
    mlocked = 1'b1; mstep = 0; midx = 8'h00; mldn = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state locked
    op(DAT, 1'b0, 1'b1, 8'h00, "R1");
    op(IDX, 1'b0, 1'b1, 8'h00, "R1");
    // R4: locked writes ignored
    op(DAT, 1'b1, 1'b0, 8'h99, "R4");
    // R3: broken key stays locked
    op(IDX, 1'b1, 1'b0, 8'h87, "R3"); op(IDX, 1'b1, 1'b0, 8'h01, "R3");
    op(IDX, 1'b1, 1'b0, 8'hAA, "R3"); op(IDX, 1'b1, 1'b0, 8'h55, "R3");
    op(IDX, 1'b1, 1'b0, 8'h55, "R3");
    op(DAT, 1'b0, 1'b1, 8'h00, "R3");
    // R3: stray 0x87 restarts at step one; R2: intervening data access harmless
    op(IDX, 1'b1, 1'b0, 8'h87, "R3"); op(IDX, 1'b1, 1'b0, 8'h87, "R3");
    op(IDX, 1'b1, 1'b0, 8'h01, "R3"); op(DAT, 1'b0, 1'b1, 8'h00, "R2");
    op(IDX, 1'b1, 1'b0, 8'h55, "R3");
    // R12: last key byte with simultaneous index read returns locked value
    op(IDX, 1'b1, 1'b1, 8'h55, "R12");
    op(IDX, 1'b0, 1'b1, 8'h00, "R2");
    // R1/R6: device number reset value, then write and read back
    op(IDX, 1'b1, 1'b0, 8'h07);
    op(DAT, 1'b0, 1'b1, 8'h00, "R1");
    op(DAT, 1'b1, 1'b0, 8'h05); op(DAT, 1'b0, 1'b1, 8'h00, "R6");
    // R7, R8
    op(IDX, 1'b1, 1'b0, 8'h20); op(DAT, 1'b0, 1'b1, 8'h00, "R7");
    op(DAT, 1'b1, 1'b0, 8'h11); op(DAT, 1'b0, 1'b1, 8'h00, "R7");
    op(IDX, 1'b1, 1'b0, 8'h21); op(DAT, 1'b0, 1'b1, 8'h00, "R7");
    op(IDX, 1'b1, 1'b0, 8'h22); op(DAT, 1'b1, 1'b1, 8'hF7, "R8");
    op(DAT, 1'b0, 1'b1, 8'h00, "R8");
    // R10 forwarding, R11 holes
    op(IDX, 1'b1, 1'b0, 8'h30); op(DAT, 1'b1, 1'b0, 8'hA5, "R10");
    op(IDX, 1'b1, 1'b0, 8'hFF); op(DAT, 1'b0, 1'b1, 8'h00, "R10");
    op(IDX, 1'b1, 1'b0, 8'h2F); op(DAT, 1'b1, 1'b1, 8'h44, "R11");
    op(IDX, 1'b1, 1'b0, 8'h00); op(DAT, 1'b0, 1'b1, 8'h00, "R11");
    // R13
    op(OTH, 1'b1, 1'b1, 8'h02, "R13");
    // R9: wrong code keeps open, lock code with read closes
    op(IDX, 1'b1, 1'b0, 8'h02); op(DAT, 1'b1, 1'b0, 8'h03, "R9");
    op(DAT, 1'b0, 1'b1, 8'h00, "R9");
    op(DAT, 1'b1, 1'b1, 8'h02, "R12");
    op(DAT, 1'b0, 1'b1, 8'h00, "R9");
    op(IDX, 1'b0, 1'b1, 8'h00, "R9");

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 19) == 0 && mlocked) send_key();
      case ($urandom_range(0, 9))
        0: a = OTH;
        1, 2, 3, 4: a = IDX;
        default: a = DAT;
      endcase
      w = ($urandom_range(0, 9) < 6);
      r = ($urandom_range(0, 9) < 6);
      case ($urandom_range(0, 9))
        0: d = 8'h02;
        1: d = 8'h07;
        2: d = 8'h20 + 8'($urandom_range(0, 2));
        3, 4: d = kb[$urandom_range(0, 3)];
        5, 6: d = 8'h30 + 8'($urandom_range(0, 15));
        default: d = 8'($urandom);
      endcase
      op(a, w, r, d);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule